// File: doc/BRIEF.md
# Speculative Dual-Carry Arithmetic Cluster

The cluster is a row of one-bit arithmetic cells. Each cell works out its result twice at the same time. One copy assumes that the carry entering the cluster is 0, and the other assumes it is 1. Each copy has its own ripple carry that runs through every bit. A single cluster carry-select input decides at the end which copy is real. Because of this, a late-arriving carry from an earlier cluster only has to drive a final multiplexer, not the whole chain.

A cluster-wide subtract control inverts operand B before it reaches both chains. Two's-complement subtraction therefore needs carry-select at 1. The selected carry-out is meant to drive the carry-select input of the next cluster.

The result is available two ways:
- **Combinational:** straight from the cells.
- **Registered:** through a result register with asynchronous reset, clock enable, synchronous clear and synchronous load. Clear has priority over load, and load has priority over the arithmetic update.

When count enable is high, the cluster changes its operands so that the cells compute the register's value plus or minus one. The same register then acts as an up/down counter. An accumulator is formed by feeding the registered result back into operand A.

Top module: `cs_arith_cluster`

## Requirements
- R1: With cnt_en low, comb_sum equals (op_a + B' + carry_sel) mod 2^WIDTH, where B' is op_b when sub_mode is 0 and the bitwise inverse of op_b when sub_mode is 1.
- R2: cout_z is the carry out of bit WIDTH-1 for the operand pair with a forced carry of 0 into bit 0. cout_o is the same carry with a forced carry of 1 into bit 0. cout_z high implies cout_o high.
- R3: cout_sel equals cout_o when the effective carry select is 1, and cout_z otherwise. With sub_mode=1 and carry_sel=1, comb_sum is op_a - op_b and cout_sel is 1 exactly when op_a >= op_b (unsigned).
- R4: On a clock edge with clk_en high and both sclr and sload low, reg_sum takes the comb_sum value present before that edge.
- R5: On a clock edge with clk_en and sclr high, reg_sum becomes 0, whatever sload and cnt_en are.
- R6: On a clock edge with clk_en and sload high and sclr low, reg_sum takes load_val, whatever cnt_en is.
- R7: With clk_en low, reg_sum does not change at a clock edge, whatever the other controls are.
- R8: With cnt_en high, the cells compute reg_sum+1 when cnt_up=1 and reg_sum-1 when cnt_up=0. Operands and sub_mode are ignored in this mode, and carry_sel is replaced by cnt_up. Counting wraps all-ones to 0 going up and 0 to all-ones going down. cout_sel is 1 on the up wrap and, when counting down, 1 whenever reg_sum is not 0.
- R9: While rst_n is low, reg_sum is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| sub_mode | input | 1 | 1: invert operand B (subtract) |
| carry_sel | input | 1 | Cluster carry-in; selects the chain |
| clk_en | input | 1 | Clock enable for the result register |
| cnt_en | input | 1 | Counter mode: cells add ±1 to the register |
| cnt_up | input | 1 | Count direction, 1 = up |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load |
| load_val | input | WIDTH | Value for synchronous load |
| comb_sum | output | WIDTH | Unregistered result |
| reg_sum | output | WIDTH | Registered result |
| cout_z | output | 1 | Chain-0 carry-out |
| cout_o | output | 1 | Chain-1 carry-out |
| cout_sel | output | 1 | Selected carry-out, for cascading |

## Verification
Directed patterns cover the cases that separate the two chains:
- addition with both carry-select values, which shows whether the wrong chain's sums leak through;
- subtraction of equal, larger and smaller operands, which checks the borrow sense of cout_sel;
- counting up from all-ones and down from zero, which exercises wraparound and the forced-carry choice.

Random cycles then mix every control combination, including clear, load and count all asserted together, and clock enable dropped. This separates priority errors from errors in the arithmetic itself. A behavioural reference in the bench predicts every output on every cycle.

// File: rtl/cs_arith_pkg.sv
package cs_arith_pkg;
   // Action taken by the result register at an enabled edge
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_CLEAR = 2'd1,
      ACT_LOAD  = 2'd2,
      ACT_STEP  = 2'd3
   } cs_act_e;

   function automatic cs_act_e cs_pick_action(input logic ce, input logic clr, input logic ld);
      cs_act_e act;
      if (!ce)      act = ACT_HOLD;
      else if (clr) act = ACT_CLEAR;
      else if (ld)  act = ACT_LOAD;
      else          act = ACT_STEP;
      return act;
   endfunction
endpackage

// File: rtl/cs_bit_cell.sv
// One bit of the cluster: two candidate sums and two carries, one per chain.
module cs_bit_cell #(
   parameter bit ADD_FORM = 1'b0   // 1: arithmetic form, 0: explicit gate form
) (
   input  logic a,
   input  logic b,
   input  logic ci_z,
   input  logic ci_o,
   output logic s_z,
   output logic s_o,
   output logic co_z,
   output logic co_o
);
   generate
      if (ADD_FORM) begin : g_add
         assign {co_z, s_z} = {1'b0, a} + {1'b0, b} + {1'b0, ci_z};
         assign {co_o, s_o} = {1'b0, a} + {1'b0, b} + {1'b0, ci_o};
      end else begin : g_gate
         logic p, g;
         assign p    = a ^ b;
         assign g    = a & b;
         assign s_z  = p ^ ci_z;
         assign s_o  = p ^ ci_o;
         assign co_z = g | (p & ci_z);
         assign co_o = g | (p & ci_o);
      end
   endgenerate
endmodule

// File: rtl/cs_dual_chain.sv
// WIDTH cells with two independent ripple chains forced to 0 and 1 at bit 0.
module cs_dual_chain #(
   parameter int WIDTH    = 10,
   parameter bit ADD_FORM = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum_z,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_z,
   output logic             cout_o
);
   logic [WIDTH:0] cz, co;

   assign cz[0] = 1'b0;
   assign co[0] = 1'b1;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         cs_bit_cell #(.ADD_FORM(ADD_FORM)) u_cell (
            .a    (a[i]),
            .b    (b[i]),
            .ci_z (cz[i]),
            .ci_o (co[i]),
            .s_z  (sum_z[i]),
            .s_o  (sum_o[i]),
            .co_z (cz[i+1]),
            .co_o (co[i+1])
         );
      end
   endgenerate

   assign cout_z = cz[WIDTH];
   assign cout_o = co[WIDTH];
endmodule

// File: rtl/cs_operand_mux.sv
// Chooses the cell operands and carry select: external operands or counter step.
module cs_operand_mux #(
   parameter int WIDTH = 10
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [WIDTH-1:0] cur,
   input  logic             sub_mode,
   input  logic             carry_sel,
   input  logic             cnt_en,
   input  logic             cnt_up,
   output logic [WIDTH-1:0] a_eff,
   output logic [WIDTH-1:0] b_eff,
   output logic             sel_eff
);
   logic [WIDTH-1:0] b_raw;
   logic             inv;

   always_comb begin
      if (cnt_en) begin
         // up: cur + 0 + 1 ; down: cur + all-ones + 0
         a_eff   = cur;
         b_raw   = '0;
         inv     = ~cnt_up;
         sel_eff = cnt_up;
      end else begin
         a_eff   = op_a;
         b_raw   = op_b;
         inv     = sub_mode;
         sel_eff = carry_sel;
      end
      b_eff = inv ? ~b_raw : b_raw;
   end
endmodule

// File: rtl/cs_result_reg.sv
// Result register: clear over load over step, all gated by clock enable.
module cs_result_reg
   import cs_arith_pkg::*;
#(
   parameter int WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             clr,
   input  logic             ld,
   input  logic [WIDTH-1:0] ld_val,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   cs_act_e act;
   assign act = cs_pick_action(ce, clr, ld);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         case (act)
            ACT_CLEAR: q <= '0;
            ACT_LOAD:  q <= ld_val;
            ACT_STEP:  q <= d;
            default:   q <= q;
         endcase
      end
   end

   // R5: clear wins
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && clr) |=> (q == '0));
   // R6: load below clear
   a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !clr && ld) |=> (q == $past(ld_val)));
   // R7: no enable, no change
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(q));
   // R4: arithmetic capture
   a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !clr && !ld) |=> (q == $past(d)));
endmodule

// File: rtl/cs_arith_cluster.sv
module cs_arith_cluster #(
   parameter int WIDTH    = 10,
   parameter bit ADD_FORM = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             sub_mode,
   input  logic             carry_sel,
   input  logic             clk_en,
   input  logic             cnt_en,
   input  logic             cnt_up,
   input  logic             sclr,
   input  logic             sload,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] comb_sum,
   output logic [WIDTH-1:0] reg_sum,
   output logic             cout_z,
   output logic             cout_o,
   output logic             cout_sel
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("cs_arith_cluster: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] a_eff, b_eff, sum_z, sum_o;
   logic             sel_eff;

   cs_operand_mux #(.WIDTH(WIDTH)) u_mux (
      .op_a      (op_a),
      .op_b      (op_b),
      .cur       (reg_sum),
      .sub_mode  (sub_mode),
      .carry_sel (carry_sel),
      .cnt_en    (cnt_en),
      .cnt_up    (cnt_up),
      .a_eff     (a_eff),
      .b_eff     (b_eff),
      .sel_eff   (sel_eff)
   );

   cs_dual_chain #(.WIDTH(WIDTH), .ADD_FORM(ADD_FORM)) u_chain (
      .a      (a_eff),
      .b      (b_eff),
      .sum_z  (sum_z),
      .sum_o  (sum_o),
      .cout_z (cout_z),
      .cout_o (cout_o)
   );

   // Late carry only drives the final selection
   assign comb_sum = sel_eff ? sum_o : sum_z;
   assign cout_sel = sel_eff ? cout_o : cout_z;

   cs_result_reg #(.WIDTH(WIDTH)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce     (clk_en),
      .clr    (sclr),
      .ld     (sload),
      .ld_val (load_val),
      .d      (comb_sum),
      .q      (reg_sum)
   );

   // R2: the carry-1 chain never carries less than the carry-0 chain
   a_r2_chain_dominance: assert property (@(posedge clk) disable iff (!rst_n)
      cout_z |-> cout_o);
   // R8: counting up steps by one, with wrap
   a_r8_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !sclr && !sload && cnt_en && cnt_up)
      |=> (reg_sum == WIDTH'($past(reg_sum) + 1'b1)));
   // R8: counting down steps by one, with wrap
   a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !sclr && !sload && cnt_en && !cnt_up)
      |=> (reg_sum == WIDTH'($past(reg_sum) - 1'b1)));
   // R8: the up-count carry marks the wrap from all-ones
   a_r8_up_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && cnt_up) |-> (cout_sel == (reg_sum == ALL_ONES)));
endmodule

// File: tb/cs_arith_cluster_bench.sv
module cs_arith_cluster_bench;
   localparam int W    = 10;
   localparam int MASK = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0, load_val = '0;
   logic         sub_mode = 1'b0, carry_sel = 1'b0, clk_en = 1'b0, cnt_en = 1'b0;
   logic         cnt_up = 1'b0, sclr = 1'b0, sload = 1'b0;
   logic [W-1:0] comb_sum, reg_sum;
   logic         cout_z, cout_o, cout_sel;

   int total = 0;
   int bad   = 0;
   int model_reg = 0;
   string reg_tag = "R9";

   always #10 clk = ~clk;   // 50 MHz

   cs_arith_cluster #(.WIDTH(W)) u_cs_arith_cluster (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode),
      .carry_sel(carry_sel), .clk_en(clk_en), .cnt_en(cnt_en), .cnt_up(cnt_up),
      .sclr(sclr), .sload(sload), .load_val(load_val), .comb_sum(comb_sum),
      .reg_sum(reg_sum), .cout_z(cout_z), .cout_o(cout_o), .cout_sel(cout_sel)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One cycle: inputs driven after a falling edge, checked before and after the rising edge
   task automatic step(input int a, input int b, input bit sub, input bit cs,
                       input bit ce, input bit cnt, input bit up,
                       input bit clr, input bit ld, input int lv);
      int ea, eb, eci, t0, t1, esum, ecz, eco, esel;
      check(reg_tag, int'(reg_sum), model_reg);
      op_a = W'(a); op_b = W'(b); sub_mode = sub; carry_sel = cs;
      clk_en = ce; cnt_en = cnt; cnt_up = up; sclr = clr; sload = ld; load_val = W'(lv);
      if (cnt) begin
         ea = model_reg; eb = up ? 0 : MASK; eci = up;
      end else begin
         ea = a & MASK; eb = sub ? (~b & MASK) : (b & MASK); eci = cs;
      end
      t0 = ea + eb; t1 = ea + eb + 1;
      ecz  = (t0 >> W) & 1;
      eco  = (t1 >> W) & 1;
      esum = (eci ? t1 : t0) & MASK;
      esel = eci ? eco : ecz;
      #2;
      check(cnt ? "R8 comb_sum" : "R1 comb_sum", int'(comb_sum), esum);
      check("R2 cout_z", int'(cout_z), ecz);
      check("R2 cout_o", int'(cout_o), eco);
      check(cnt ? "R8 cout_sel" : "R3 cout_sel", int'(cout_sel), esel);
      if (!ce)       reg_tag = "R7 hold";
      else if (clr)  reg_tag = "R5 clear";
      else if (ld)   reg_tag = "R6 load";
      else if (cnt)  reg_tag = "R8 count";
      else           reg_tag = "R4 capture";
      if (ce) begin
         if (clr)     model_reg = 0;
         else if (ld) model_reg = lv & MASK;
         else         model_reg = esum;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset", int'(reg_sum), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1/R3 add with both carry selects
      step(10'h155, 10'h0AA, 0, 0, 1, 0, 0, 0, 0, 0);
      step(10'h3FF, 10'h001, 0, 1, 1, 0, 0, 0, 0, 0);
      step(10'h3FF, 10'h000, 0, 1, 1, 0, 0, 0, 0, 0);
      // R3 subtraction: equal, larger, smaller
      step(10'h123, 10'h123, 1, 1, 1, 0, 0, 0, 0, 0);
      step(10'h200, 10'h011, 1, 1, 1, 0, 0, 0, 0, 0);
      step(10'h011, 10'h200, 1, 1, 1, 0, 0, 0, 0, 0);
      // R8 wrap up from all-ones
      step(0, 0, 0, 0, 1, 0, 0, 0, 1, 10'h3FE);
      step(10'h0F0, 10'h00F, 1, 0, 1, 1, 1, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 1, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 1, 0, 0, 0);
      // R8 wrap down from zero
      step(10'h3FF, 10'h3FF, 0, 1, 1, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
      // R7 hold with everything else asserted
      step(10'h0AB, 10'h0CD, 0, 1, 0, 1, 1, 1, 1, 10'h111);
      step(10'h0AB, 10'h0CD, 0, 1, 0, 0, 0, 0, 0, 0);
      // R5 clear beats load; R6 load beats count
      step(1, 2, 0, 0, 1, 1, 1, 1, 1, 10'h2A5);
      step(1, 2, 0, 0, 1, 1, 0, 0, 1, 10'h2A5);
      step(1, 2, 0, 0, 1, 0, 0, 0, 0, 0);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         step(int'($urandom_range(0, MASK)), int'($urandom_range(0, MASK)),
              bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
              r < 90, r < 35, bit'($urandom_range(0, 1)),
              r % 13 == 0, r % 7 == 0, int'($urandom_range(0, MASK)));
      end
      check(reg_tag, int'(reg_sum), model_reg);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule